// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block works out the divider settings for a frequency synthesiser. It takes a requested pixel clock and a reference clock, both in kHz. It runs an ordered search over three settings and returns the combination whose output comes closest to the request:

- a prescale divisor N, which divides the reference down to an internal comparison frequency;
- a feedback multiplier M;
- a post-divider shift P.

Every candidate must keep the internal comparison frequency and the oscillator frequency inside their legal windows. The engine reports the three 8-bit settings, the clock they produce (in 100 Hz units) and a flag that says whether any legal combination was found. A one-cycle completion pulse marks the moment these results change.

All division goes through a single shared multi-cycle restoring divider, so a search takes a few hundred to a few tens of thousands of cycles, depending on how many postscale values survive pruning. The usual use is at mode-set time: assert `start` for one cycle with both frequencies stable, wait for `done`, then copy the settings into the synthesiser's registers.

Top module: `pll_coef_search`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `found` are 0, and `pre_n`, `fb_m`, `post_p` and `achieved` are all 0.
- R2: Handling of `start`:
  - `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance.
  - Both input frequencies are captured at acceptance, so later changes to them have no effect on the result.
  - A `start` pulse while `busy` is high is ignored: the search in progress continues and its result is unchanged.
- R3: `done` is high for exactly one cycle per search. In that same cycle `busy` is low and the outputs carry the new result.
- R4: Both inputs are scaled by 10 into 100 Hz units before any arithmetic. When a result is found, `achieved` equals floor(floor(2 × ref×10 × M / N) / 2^P), computed from the returned settings.
- R5: Any returned result obeys all of the following:
  - P is in 0..5.
  - N is in 1..255.
  - M is at most 255.
  - floor(ref×10 / N) lies within 10000..20000 inclusive.
  - floor(2 × ref×10 × M / N) lies within 2000000..6220000 inclusive.
- R6: Search order and selection:
  - P ascends from 0 to 5 as the outer loop; N ascends from 1 to 255 inside it.
  - For each N the engine tries M = floor(N × 2^P × req×10 / (2 × ref×10)) and then M+1. Only M is tried when M is 255.
  - A legal candidate replaces the best only if its absolute error against req×10 is strictly smaller. The best error starts at 1000000.
  - On equal error, the earlier candidate is kept.
- R7: Pruning and loop cuts:
  - A postscale value P is skipped when its oscillator span cannot reach the legal window. The span is bounded by the oscillator at N = 1 and at N = 255, each using the M formula of R6. P is skipped if the N = 255 bound is below the window or the N = 1 bound is above it.
  - Inside the N loop, an internal frequency above 20000 moves on to the next N.
  - An internal frequency below 10000 ends the current P, and so does a computed M above 255.
- R8: A candidate with zero error ends the search at once with that candidate as the result, so `done` arrives earlier than for a full search.
- R9: If no legal candidate exists, `found` is 0 and `achieved`, `pre_n`, `fb_m` and `post_p` are all 0 at `done`.
- R10: `found`, `pre_n`, `fb_m`, `post_p` and `achieved` change only in the `done` cycle. They hold their last values between searches and throughout a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a search |
| req_khz | input | REQ_W | Requested output clock in kHz |
| ref_khz | input | REQ_W | Reference clock in kHz, nonzero |
| busy | output | 1 | High while a search runs |
| done | output | 1 | One-cycle pulse when results update |
| found | output | 1 | A legal setting was found |
| pre_n | output | 8 | Prescale divisor N |
| fb_m | output | 8 | Feedback multiplier M |
| post_p | output | 8 | Postscale shift P |
| achieved | output | REQ_W+4 | Achieved clock in 100 Hz units, 0 when none found |

## Verification
The oscillator-frequency quotient can, in a single cycle, both install a new best candidate and end the search because its error is zero. If the zero-error exit fired a cycle early or late, the wrong candidate would be latched or a later one would replace it. This case is provoked with a 214770 kHz request on a 14318 kHz reference, which is matched exactly by the first legal candidate. It is judged on two counts: the returned settings and clock must equal the exact match, and completion must come sooner than for a 214760 kHz request, which has to run the whole search. A second start pulse is also injected partway through a search with a different request on the inputs, and the result must still match the originally captured request.

// File: rtl/pll_search_pkg.sv
// Shared types and constants for the PLL coefficient search engine.
// Assumes all frequencies are carried in 100 Hz units inside the engine.
package pll_search_pkg;

    // Controller states: prune phase (PLO/PHI/PHV), then N loop (NFI/NM/NV)
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLO,
        ST_PHI,
        ST_PHV,
        ST_NFI,
        ST_NM,
        ST_NV,
        ST_FIN
    } srch_state_t;

    // Legal windows and seed error, all in 100 Hz units
    localparam logic [31:0] VCO_LO   = 32'd2000000;
    localparam logic [31:0] VCO_HI   = 32'd6220000;
    localparam logic [31:0] IREF_LO  = 32'd10000;
    localparam logic [31:0] IREF_HI  = 32'd20000;
    localparam logic [31:0] ERR_SEED = 32'd1000000;

    // Loop limits
    localparam logic [2:0]  POST_LAST   = 3'd5;
    localparam logic [7:0]  SETTING_TOP = 8'd255;

endpackage

// File: rtl/pll_iter_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: go is pulsed only while idle; divisor is nonzero.
// Latency: quotient valid and done pulsed DW cycles after go.
module pll_iter_div #(
    parameter int DW = 38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic          done
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] rem_q;
    logic [DW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   rem_sh;
    logic          fits;

    // Shift in the next dividend bit and test whether the divisor fits
    always_comb begin
        rem_sh = {rem_q, quotient[DW-1]};
        fits   = rem_sh >= {1'b0, dvs_q};
    end

    // Iteration register: partial remainder, dividend/quotient shifter, count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q    <= '0;
                dvs_q    <= divisor;
                quotient <= dividend;
                cnt_q    <= CW'(DW);
                run_q    <= 1'b1;
            end else if (run_q) begin
                rem_q    <= fits ? DW'(rem_sh - {1'b0, dvs_q}) : DW'(rem_sh);
                quotient <= {quotient[DW-2:0], fits};
                cnt_q    <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pll_cand_score.sv
// Scores one oscillator candidate against the request and the best so far.
// Purely combinational; assumes shift <= 5 and req/best in 100 Hz units.
module pll_cand_score
    import pll_search_pkg::*;
#(
    parameter int DW    = 38,
    parameter int ACT_W = 24
) (
    input  logic [DW-1:0]    vco,
    input  logic [2:0]       shift,
    input  logic [ACT_W-1:0] req,
    input  logic [ACT_W-1:0] best_err,
    output logic [ACT_W-1:0] act,
    output logic [ACT_W-1:0] err,
    output logic             better,
    output logic             exact
);
    logic legal;

    // Window test, post-divided clock, absolute error, strict improvement
    always_comb begin
        legal  = (vco >= DW'(VCO_LO)) && (vco <= DW'(VCO_HI));
        act    = ACT_W'(vco >> shift);
        err    = (act >= req) ? (act - req) : (req - act);
        better = legal && (err < best_err);
        exact  = better && (err == '0);
    end

endmodule

// File: rtl/pll_coef_search.sv
// Ordered search for PLL prescale N, feedback M and postscale P.
// For each P (0..5), prunes on the oscillator span, then walks N upward,
// trying M and M+1, keeping the strictly closest legal candidate.
// Assumes ref_khz is nonzero and start is a pulse; all outputs registered.
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int REQ_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [REQ_W-1:0]   req_khz,
    input  logic [REQ_W-1:0]   ref_khz,
    output logic               busy,
    output logic               done,
    output logic               found,
    output logic [7:0]         pre_n,
    output logic [7:0]         fb_m,
    output logic [7:0]         post_p,
    output logic [REQ_W+3:0]   achieved
);
    localparam int ACT_W = REQ_W + 4;
    localparam int DW    = REQ_W + 18;

    srch_state_t      state;
    logic [ACT_W-1:0] req_q, ref_q;
    logic [DW-1:0]    lo_v, mh_q, two_ref;
    logic [2:0]       p_q;
    logic [7:0]       n_q, m_q;
    logic             m_second, div_wait;

    logic [7:0]       best_n, best_m;
    logic [2:0]       best_p;
    logic [ACT_W-1:0] best_act, best_err;
    logic             best_found;

    logic             div_go, div_done, arith;
    logic [DW-1:0]    div_dvd, div_dvs, div_q;

    logic [ACT_W-1:0] sc_act, sc_err;
    logic             sc_better, sc_exact;

    srch_state_t      p_next_state, n_next_state;
    logic [2:0]       n_next_p;

    // Loop-advance decisions shared by several states
    always_comb begin
        two_ref      = DW'(ref_q) << 1;
        p_next_state = (p_q == POST_LAST) ? ST_FIN : ST_PLO;
        n_next_state = (n_q == SETTING_TOP) ? p_next_state : ST_NFI;
        n_next_p     = (n_q == SETTING_TOP) ? p_q + 3'd1 : p_q;
    end

    // Operand selection for the shared divider, one division per state
    always_comb begin
        arith   = 1'b1;
        div_dvd = '0;
        div_dvs = DW'(1);
        case (state)
            ST_PLO: begin
                div_dvd = DW'(req_q) << p_q;
                div_dvs = two_ref;
            end
            ST_PHI: begin
                div_dvd = (DW'(req_q) * DW'(SETTING_TOP)) << p_q;
                div_dvs = two_ref;
            end
            ST_PHV: begin
                div_dvd = two_ref * mh_q;
                div_dvs = DW'(SETTING_TOP);
            end
            ST_NFI: begin
                div_dvd = DW'(ref_q);
                div_dvs = DW'(n_q);
            end
            ST_NM: begin
                div_dvd = (DW'(req_q) * DW'(n_q)) << p_q;
                div_dvs = two_ref;
            end
            ST_NV: begin
                div_dvd = two_ref * DW'(m_q);
                div_dvs = DW'(n_q);
            end
            default: arith = 1'b0;
        endcase
        div_go = arith && !div_wait;
    end

    pll_iter_div #(.DW(DW)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .quotient (div_q),
        .done     (div_done)
    );

    pll_cand_score #(.DW(DW), .ACT_W(ACT_W)) i_score (
        .vco      (div_q),
        .shift    (p_q),
        .req      (req_q),
        .best_err (best_err),
        .act      (sc_act),
        .err      (sc_err),
        .better   (sc_better),
        .exact    (sc_exact)
    );

    // Search controller: loop indices, best-candidate record, result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            ref_q      <= '0;
            lo_v       <= '0;
            mh_q       <= '0;
            p_q        <= '0;
            n_q        <= '0;
            m_q        <= '0;
            m_second   <= 1'b0;
            div_wait   <= 1'b0;
            best_n     <= '0;
            best_m     <= '0;
            best_p     <= '0;
            best_act   <= '0;
            best_err   <= '0;
            best_found <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
            found      <= 1'b0;
            pre_n      <= '0;
            fb_m       <= '0;
            post_p     <= '0;
            achieved   <= '0;
        end else begin
            done <= 1'b0;
            if (div_go)   div_wait <= 1'b1;
            if (div_done) div_wait <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    req_q      <= {4'd0, req_khz} * ACT_W'(10);
                    ref_q      <= {4'd0, ref_khz} * ACT_W'(10);
                    p_q        <= '0;
                    best_n     <= '0;
                    best_m     <= '0;
                    best_p     <= '0;
                    best_act   <= '0;
                    best_err   <= ACT_W'(ERR_SEED);
                    best_found <= 1'b0;
                    busy       <= 1'b1;
                    state      <= ST_PLO;
                end
                ST_PLO: if (div_done) begin
                    lo_v  <= two_ref * div_q;
                    state <= ST_PHI;
                end
                ST_PHI: if (div_done) begin
                    mh_q  <= div_q;
                    state <= ST_PHV;
                end
                ST_PHV: if (div_done) begin
                    if (div_q < DW'(VCO_LO) || lo_v > DW'(VCO_HI)) begin
                        p_q   <= p_q + 3'd1;
                        state <= p_next_state;
                    end else begin
                        n_q   <= 8'd1;
                        state <= ST_NFI;
                    end
                end
                ST_NFI: if (div_done) begin
                    if (div_q > DW'(IREF_HI)) begin
                        n_q   <= n_q + 8'd1;
                        p_q   <= n_next_p;
                        state <= n_next_state;
                    end else if (div_q < DW'(IREF_LO)) begin
                        p_q   <= p_q + 3'd1;
                        state <= p_next_state;
                    end else begin
                        state <= ST_NM;
                    end
                end
                ST_NM: if (div_done) begin
                    if (div_q > DW'(SETTING_TOP)) begin
                        p_q   <= p_q + 3'd1;
                        state <= p_next_state;
                    end else begin
                        m_q      <= div_q[7:0];
                        m_second <= (div_q[7:0] != SETTING_TOP);
                        state    <= ST_NV;
                    end
                end
                ST_NV: if (div_done) begin
                    if (sc_better) begin
                        best_n     <= n_q;
                        best_m     <= m_q;
                        best_p     <= p_q;
                        best_act   <= sc_act;
                        best_err   <= sc_err;
                        best_found <= 1'b1;
                    end
                    if (sc_exact) begin
                        state <= ST_FIN;
                    end else if (m_second) begin
                        m_q      <= m_q + 8'd1;
                        m_second <= 1'b0;
                    end else begin
                        n_q   <= n_q + 8'd1;
                        p_q   <= n_next_p;
                        state <= n_next_state;
                    end
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    busy     <= 1'b0;
                    found    <= best_found;
                    pre_n    <= best_n;
                    fb_m     <= best_m;
                    post_p   <= {5'd0, best_p};
                    achieved <= best_found ? best_act : '0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_coef_search_chk.sv
// Port-level protocol and result-shape checks for pll_coef_search.
// Attached to every instance of the top by the bind at the end of this file.
module pll_coef_search_chk #(
    parameter int REQ_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             found,
    input logic [7:0]       pre_n,
    input logic [7:0]       fb_m,
    input logic [7:0]       post_p,
    input logic [REQ_W+3:0] achieved
);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(achieved) && $stable(found) && $stable(pre_n)
                   && $stable(fb_m) && $stable(post_p)));

    assert_none_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (achieved == '0 && pre_n == 8'd0
                              && fb_m == 8'd0 && post_p == 8'd0));

    assert_setting_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (pre_n != 8'd0 && post_p <= 8'd5 && achieved != '0));

endmodule

bind pll_coef_search pll_coef_search_chk #(.REQ_W(REQ_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .pre_n    (pre_n),
    .fb_m     (fb_m),
    .post_p   (post_p),
    .achieved (achieved)
);

// File: tb/test_pll_coef_search.sv
// Self-checking bench: sweeps requests over several references and compares
// each result with an arithmetic model of the ordered search.
module test_pll_coef_search;
    localparam int REQ_W = 20;
    localparam int ACT_W = REQ_W + 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [REQ_W-1:0] req_khz = '0;
    logic [REQ_W-1:0] ref_khz = '0;
    logic             busy, done, found;
    logic [7:0]       pre_n, fb_m, post_p;
    logic [ACT_W-1:0] achieved;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pll_coef_search #(.REQ_W(REQ_W)) i_pll_coef_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_khz  (req_khz),
        .ref_khz  (ref_khz),
        .busy     (busy),
        .done     (done),
        .found    (found),
        .pre_n    (pre_n),
        .fb_m     (fb_m),
        .post_p   (post_p),
        .achieved (achieved)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Ordered search model from the requirements (R6, R7, R8)
    function automatic void search_model(input longint rk, input longint fk,
            output bit f, output int bn, output int bm, output int bp,
            output longint ba);
        longint rq = rk * 10;
        longint rf = fk * 10;
        longint best = 1000000;
        longint m, lo, hi, fi, v, a, e;
        bit stop = 0;
        f = 0; bn = 0; bm = 0; bp = 0; ba = 0;
        for (int p = 0; p <= 5 && !stop; p++) begin
            m  = (rq << p) / (2 * rf);
            lo = 2 * rf * m;
            m  = (255 * (rq << p)) / (2 * rf);
            hi = (2 * rf * m) / 255;
            if (hi < 2000000 || lo > 6220000) continue;
            for (int n = 1; n <= 255 && !stop; n++) begin
                fi = rf / n;
                if (fi > 20000) continue;
                if (fi < 10000) break;
                m = (n * (rq << p)) / (2 * rf);
                if (m > 255) break;
                for (int k = 0; k < ((m == 255) ? 1 : 2) && !stop; k++) begin
                    v = (2 * rf * (m + k)) / n;
                    if (v >= 2000000 && v <= 6220000) begin
                        a = v >> p;
                        e = (a > rq) ? a - rq : rq - a;
                        if (e < best) begin
                            best = e; f = 1; bn = n; bm = int'(m) + k; bp = p; ba = a;
                            if (e == 0) stop = 1;
                        end
                    end
                end
            end
        end
    endfunction

    // One search: start, optional mid-run start poke, wait, compare
    task automatic run_one(input int rq, input int rf, input bit poke, output int lat);
        bit ef; int en, em, ep; longint ea, prev, rf10, vco, fi;
        search_model(rq, rf, ef, en, em, ep, ea);
        prev = achieved;
        @(negedge clk);
        req_khz = REQ_W'(rq); ref_khz = REQ_W'(rf); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after accepted start", busy, 1);
        lat = 1;
        while (!done && lat < 40000) begin
            if (poke && lat == 30) begin
                start = 1'b1; req_khz = REQ_W'(rq + 1234);
            end else begin
                start = 1'b0;
            end
            if (poke && lat == 31) chk("R2 start while busy ignored", busy, 1);
            if (lat == 20) chk("R10 result held during search", achieved, prev);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R3 done reached", done, 1);
        chk("R3 busy low in done cycle", busy, 0);
        chk("R6 found", found, ef);
        chk("R6 prescale N", pre_n, en);
        chk("R6 feedback M", fb_m, em);
        chk("R6 postscale P", post_p, ep);
        chk("R6 achieved clock", achieved, ea);
        if (found) begin
            rf10 = longint'(rf) * 10;
            vco  = (2 * rf10 * fb_m) / pre_n;
            fi   = rf10 / pre_n;
            chk("R4 achieved from settings", achieved, vco >> post_p);
            chk("R5 internal ref window", (fi >= 10000 && fi <= 20000), 1);
            chk("R5 oscillator window", (vco >= 2000000 && vco <= 6220000), 1);
            chk("R5 postscale limit", (post_p <= 5), 1);
        end else begin
            chk("R9 none found clock zero", achieved, 0);
            chk("R9 none found settings zero", pre_n + fb_m + post_p, 0);
        end
        @(negedge clk);
        chk("R3 done single cycle", done, 0);
        chk("R10 result held after done", achieved, ea);
    endtask

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Main sequence
    initial begin
        int lat_exact, lat_near, lat;
        int sweep[10] = '{25175, 31500, 40000, 65000, 108000,
                          135000, 157500, 230000, 300000, 6000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 found after reset", found, 0);
        chk("R1 settings after reset", pre_n + fb_m + post_p, 0);
        chk("R1 achieved after reset", achieved, 0);

        foreach (sweep[i]) run_one(sweep[i], 14318, (i == 3), lat);

        // Exact match ends early (R8)
        run_one(214770, 14318, 0, lat_exact);
        chk("R8 exact clock", achieved, 2147700);
        run_one(214760, 14318, 0, lat_near);
        chk("R8 exact search finishes sooner", (lat_exact < lat_near), 1);

        // Unreachable requests (R9), other references (R4, R7)
        run_one(1000, 14318, 0, lat);
        run_one(700000, 14318, 0, lat);
        run_one(74250, 27000, 0, lat);
        run_one(148500, 27000, 1, lat);
        run_one(100000, 10000, 0, lat);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule